// File: doc/BRIEF.md
# USB host port control and status register

This block is the per-port control and status register of a USB 2.0 host controller. Software writes it to put the port into reset, to suspend it and to drive resume signaling. The hardware side reports remote wakeup, disconnect and an overcurrent level. Each bit merges software writes with hardware set and clear events, and each follows its own access rule.

The register outputs drive the rest of the port logic. The block asserts a reset-signaling enable and a resume-signaling enable. It gates SOF generation off while the port is suspended. It raises a PHY suspend request only when software has also set a clock-stop bit. Software alone times the reset period: the block holds the reset bit until software clears it.

Bit positions: 4 overcurrent active (read-only), 5 overcurrent change (write 1 to clear), 6 resume, 7 suspend, 8 port reset, 12 clock stop. All other bits read 0.

Top module: `usb_hport_ctl`

## Requirements
- R1: After reset, every register bit reads 0. `port_rst_o`, `port_resume_o` and `phy_suspend_o` are 0, and `sof_en_o` is 1.
- R2: Bit 8 (port reset) takes the written value on every write, and `port_rst_o` follows it. No hardware event clears it, and a disconnect pulse leaves it set.
- R3: Bit 7 (suspend) takes the written value on a write. While it is 1, `sof_en_o` is 0 and the bit reads back as 1.
- R4: A `wakeup_det_i` or `disconn_det_i` pulse clears bit 7 at the next edge. If bit 7 is written to 1 in the same cycle as such a pulse, the clear wins.
- R5: A write with bit 8 or bit 6 set clears bit 7, even when the same write has bit 7 set.
- R6: `phy_suspend_o` is 1 only while bit 7 is 1 and bit 12 (clock stop, read/write) is also 1.
- R7: Bit 6 (resume) takes the written value on a write, and `port_resume_o` follows it.
- R8: A `wakeup_det_i` pulse sets bit 6 without a write. A `disconn_det_i` pulse clears bit 6. When both pulses arrive together, bit 6 ends at 0.
- R9: Bit 4 shows `oc_i` after two synchronizing flops. A level change applied before edge k reads back after edge k+1.
- R10: Bit 5 is set one edge after bit 4 changes, on a rising or a falling change of bit 4.
- R11: Writing 1 to bit 5 clears it, and writing 0 to bit 5 leaves it unchanged. If a hardware set and a write-1 clear fall in the same cycle, bit 5 ends at 1.
- R12: All bits other than 4, 5, 6, 7, 8 and 12 read 0, and writing them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read value |
| wakeup_det_i | input | 1 | Remote wakeup detected pulse |
| disconn_det_i | input | 1 | Disconnect detected pulse |
| oc_i | input | 1 | Asynchronous overcurrent level |
| port_rst_o | output | 1 | Drive reset signaling |
| port_resume_o | output | 1 | Drive resume signaling |
| sof_en_o | output | 1 | SOF generation allowed |
| phy_suspend_o | output | 1 | PHY suspend request |

## Verification
Two kinds of event can fall on the same edge and need a defined winner. The first is a software write and a hardware event that touch the same bit. The bench provokes suspend written to 1 together with a disconnect, and a write-1 clear of the change bit on the edge where the synchronized overcurrent level moves. It also pulses wakeup and disconnect together. Each result is judged by reading the register on the following cycle against the priority stated in R4, R8 and R11.

// File: rtl/usb_hport_pkg.sv
package usb_hport_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned B_OC_ACT   = 4;
  localparam int unsigned B_OC_CHG   = 5;
  localparam int unsigned B_RESUME   = 6;
  localparam int unsigned B_SUSPEND  = 7;
  localparam int unsigned B_RESET    = 8;
  localparam int unsigned B_CLK_STOP = 12;

  localparam logic [REG_W-1:0] IMPL_MASK =
      (REG_W'(1) << B_OC_ACT)  | (REG_W'(1) << B_OC_CHG) |
      (REG_W'(1) << B_RESUME)  | (REG_W'(1) << B_SUSPEND) |
      (REG_W'(1) << B_RESET)   | (REG_W'(1) << B_CLK_STOP);

  typedef struct packed {
    logic clk_stop;
    logic reset;
    logic suspend;
    logic resume;
  } port_ctl_t;
endpackage

// File: rtl/usb_hport_sync.sv
module usb_hport_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/usb_hport_oc.sv
module usb_hport_oc #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oc_i,
  input  logic chg_clr_i,
  output logic oc_act_o,
  output logic oc_chg_o
);
  logic oc_sync;
  logic oc_prev_q;
  logic chg_q;

  usb_hport_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (oc_i),
    .q_o   (oc_sync)
  );

  // hardware set has priority over write-1 clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oc_prev_q <= 1'b0;
      chg_q     <= 1'b0;
    end else begin
      oc_prev_q <= oc_sync;
      if (oc_sync != oc_prev_q) chg_q <= 1'b1;
      else if (chg_clr_i)       chg_q <= 1'b0;
    end
  end

  assign oc_act_o = oc_sync;
  assign oc_chg_o = chg_q;
endmodule

// File: rtl/usb_hport_state.sv
module usb_hport_state
  import usb_hport_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      we_i,
  input  port_ctl_t wr_i,
  input  logic      wakeup_det_i,
  input  logic      disconn_det_i,
  output port_ctl_t st_o
);
  port_ctl_t st_q, st_d;
  logic      susp_kill;

  assign susp_kill = wakeup_det_i | disconn_det_i |
                     (we_i & (wr_i.reset | wr_i.resume));

  always_comb begin
    st_d = st_q;
    if (we_i) begin
      st_d.reset    = wr_i.reset;
      st_d.clk_stop = wr_i.clk_stop;
      st_d.resume   = wr_i.resume;
      st_d.suspend  = wr_i.suspend;
    end
    if (wakeup_det_i)  st_d.resume  = 1'b1;
    if (disconn_det_i) st_d.resume  = 1'b0;
    if (susp_kill)     st_d.suspend = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/usb_hport_ctl.sv
module usb_hport_ctl
  import usb_hport_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             wakeup_det_i,
  input  logic             disconn_det_i,
  input  logic             oc_i,
  output logic             port_rst_o,
  output logic             port_resume_o,
  output logic             sof_en_o,
  output logic             phy_suspend_o
);
  port_ctl_t wr_fields;
  port_ctl_t st;
  logic      oc_act, oc_chg;
  logic      unused_wdata;

  assign wr_fields.clk_stop = reg_wdata_i[B_CLK_STOP];
  assign wr_fields.reset    = reg_wdata_i[B_RESET];
  assign wr_fields.suspend  = reg_wdata_i[B_SUSPEND];
  assign wr_fields.resume   = reg_wdata_i[B_RESUME];
  assign unused_wdata = ^(reg_wdata_i & ~IMPL_MASK) ^ reg_wdata_i[B_OC_ACT];

  usb_hport_state u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (reg_we_i),
    .wr_i         (wr_fields),
    .wakeup_det_i (wakeup_det_i),
    .disconn_det_i(disconn_det_i),
    .st_o         (st)
  );

  usb_hport_oc #(.SYNC_STAGES(SYNC_STAGES)) u_oc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .oc_i     (oc_i),
    .chg_clr_i(reg_we_i & reg_wdata_i[B_OC_CHG]),
    .oc_act_o (oc_act),
    .oc_chg_o (oc_chg)
  );

  always_comb begin
    reg_rdata_o             = '0;
    reg_rdata_o[B_OC_ACT]   = oc_act;
    reg_rdata_o[B_OC_CHG]   = oc_chg;
    reg_rdata_o[B_RESUME]   = st.resume;
    reg_rdata_o[B_SUSPEND]  = st.suspend;
    reg_rdata_o[B_RESET]    = st.reset;
    reg_rdata_o[B_CLK_STOP] = st.clk_stop;
  end

  assign port_rst_o    = st.reset;
  assign port_resume_o = st.resume;
  assign sof_en_o      = ~st.suspend;
  assign phy_suspend_o = st.suspend & st.clk_stop;
endmodule

// File: rtl/usb_hport_chk.sv
module usb_hport_chk
  import usb_hport_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic             wr_chg_i,
  input logic             wr_susp_i,
  input logic             wakeup_det_i,
  input logic             disconn_det_i,
  input logic [REG_W-1:0] rdata_i,
  input logic             sof_en_i,
  input logic             phy_suspend_i
);
  p_susp_gates_sof_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_i[B_SUSPEND] |-> !sof_en_i);

  p_wake_clears_susp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wakeup_det_i |=> !rdata_i[B_SUSPEND]);

  p_clear_beats_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_susp_i && disconn_det_i) |=> !rdata_i[B_SUSPEND]);

  p_hold_reset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rdata_i[B_RESET]));

  p_phy_qual_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_suspend_i |-> (rdata_i[B_SUSPEND] && rdata_i[B_CLK_STOP]));

  p_wake_sets_res_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wakeup_det_i && !disconn_det_i) |=> rdata_i[B_RESUME]);

  p_disc_clears_res_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disconn_det_i |=> !rdata_i[B_RESUME]);

  p_edge_sets_chg_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rdata_i[B_OC_ACT]) || $fell(rdata_i[B_OC_ACT])) |=> rdata_i[B_OC_CHG]);

  p_chg_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_i[B_OC_CHG] && !(we_i && wr_chg_i)) |=> rdata_i[B_OC_CHG]);

  p_unused_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_i & ~IMPL_MASK) == '0);
endmodule

bind usb_hport_ctl usb_hport_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .we_i         (reg_we_i),
  .wr_chg_i     (reg_wdata_i[5]),
  .wr_susp_i    (reg_wdata_i[7]),
  .wakeup_det_i (wakeup_det_i),
  .disconn_det_i(disconn_det_i),
  .rdata_i      (reg_rdata_o),
  .sof_en_i     (sof_en_o),
  .phy_suspend_i(phy_suspend_o)
);

// File: tb/usb_hport_ctl_tb.sv
module usb_hport_ctl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        wakeup_det_i = 1'b0;
  logic        disconn_det_i = 1'b0;
  logic        oc_i = 1'b0;
  logic        port_rst_o, port_resume_o, sof_en_o, phy_suspend_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] rdata;
    logic [3:0]  outs;   // {rst, resume, sof_en, phy_suspend}
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  always #10 clk_i = ~clk_i;

  usb_hport_ctl u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_we_i     (reg_we_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .wakeup_det_i (wakeup_det_i),
    .disconn_det_i(disconn_det_i),
    .oc_i         (oc_i),
    .port_rst_o   (port_rst_o),
    .port_resume_o(port_resume_o),
    .sof_en_o     (sof_en_o),
    .phy_suspend_o(phy_suspend_o)
  );

  // driver: apply one cycle of stimulus, then queue what must be seen after that edge
  task automatic step(input logic we, input logic [31:0] wd, input logic wake,
                      input logic disc, input logic oc, input logic [31:0] exp_rd,
                      input logic [3:0] exp_outs, input string tag);
    exp_t e;
    @(negedge clk_i);
    reg_we_i = we; reg_wdata_i = wd; wakeup_det_i = wake;
    disconn_det_i = disc; oc_i = oc;
    @(posedge clk_i);
    #1;
    e.rdata = exp_rd; e.outs = exp_outs; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      logic [3:0] act;
      e = sb_q.pop_front();
      act = {port_rst_o, port_resume_o, sof_en_o, phy_suspend_o};
      checks++;
      if (reg_rdata_o !== e.rdata) begin
        errors++;
        $display("FAIL %s rdata actual=%h expected=%h", e.tag, reg_rdata_o, e.rdata);
      end
      checks++;
      if (act !== e.outs) begin
        errors++;
        $display("FAIL %s outs actual=%b expected=%b", e.tag, act, e.outs);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    step(0, 32'h0,    0, 0, 0, 32'h0,    4'b0010, "R1");
    // R2 reset bit, not cleared by hardware
    step(1, 32'h100,  0, 0, 0, 32'h100,  4'b1010, "R2");
    step(0, 32'h0,    0, 1, 0, 32'h100,  4'b1010, "R2_disc");
    step(1, 32'h0,    0, 0, 0, 32'h0,    4'b0010, "R2_clr");
    // R3 suspend gates SOF
    step(1, 32'h80,   0, 0, 0, 32'h80,   4'b0000, "R3");
    // R6 phy suspend needs clock stop
    step(1, 32'h1080, 0, 0, 0, 32'h1080, 4'b0001, "R6");
    step(1, 32'h1000, 0, 0, 0, 32'h1000, 4'b0010, "R6_nosusp");
    step(1, 32'h1080, 0, 0, 0, 32'h1080, 4'b0001, "R6_again");
    // R4 wakeup clears suspend, R8 sets resume
    step(0, 32'h0,    1, 0, 0, 32'h1040, 4'b0110, "R4_R8_wake");
    // R4 clear wins over same-cycle set
    step(1, 32'h80,   0, 1, 0, 32'h0,    4'b0010, "R4_race");
    step(1, 32'h80,   0, 0, 0, 32'h80,   4'b0000, "R3_set");
    // R5 resume or reset write clears suspend
    step(1, 32'hC0,   0, 0, 0, 32'h40,   4'b0110, "R5_res");
    step(1, 32'h80,   0, 0, 0, 32'h80,   4'b0000, "R7_clr");
    step(1, 32'h180,  0, 0, 0, 32'h100,  4'b1010, "R5_rst");
    step(1, 32'h0,    0, 0, 0, 32'h0,    4'b0010, "R5_idle");
    // R7 resume write
    step(1, 32'h40,   0, 0, 0, 32'h40,   4'b0110, "R7");
    // R8 disconnect beats wakeup
    step(0, 32'h0,    1, 1, 0, 32'h0,    4'b0010, "R8_both");
    // R12 unlisted bits ignored
    step(1, 32'hFFFFEE0F, 0, 0, 0, 32'h0, 4'b0010, "R12");
    // R9/R10 rising overcurrent
    step(0, 32'h0,    0, 0, 1, 32'h0,    4'b0010, "R9_sync1");
    step(0, 32'h0,    0, 0, 1, 32'h10,   4'b0010, "R9");
    step(0, 32'h0,    0, 0, 1, 32'h30,   4'b0010, "R10_rise");
    // R11 write 0 no effect, write 1 clears
    step(1, 32'h0,    0, 0, 1, 32'h30,   4'b0010, "R11_w0");
    step(1, 32'h20,   0, 0, 1, 32'h10,   4'b0010, "R11_w1c");
    // R10 falling
    step(0, 32'h0,    0, 0, 0, 32'h10,   4'b0010, "R10_f1");
    step(0, 32'h0,    0, 0, 0, 32'h0,    4'b0010, "R9_fall");
    step(0, 32'h0,    0, 0, 0, 32'h20,   4'b0010, "R10_fall");
    // R11 set wins over clear
    step(1, 32'h20,   0, 0, 1, 32'h0,    4'b0010, "R11_clr");
    step(0, 32'h0,    0, 0, 1, 32'h10,   4'b0010, "R11_s2");
    step(1, 32'h20,   0, 0, 1, 32'h30,   4'b0010, "R11_race");
    step(1, 32'h20,   0, 0, 1, 32'h10,   4'b0010, "R11_after");
    @(negedge clk_i);
    reg_we_i = 1'b0;
    repeat (2) @(negedge clk_i);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule